// File: doc/BRIEF.md
# Burst Bus Master with Reset-Safe Abandonment

This block is a bus master sequencer for a single-master AHB-Lite segment. A client hands it one command at a time: direction, start address, transfer size and a beat count of 1 to 16 in incrementing order. The sequencer then drives the pipelined address and data phases, takes write data beat by beat from a streaming source, and hands read data back beat by beat as each beat completes.

Its defining property is what happens when the active-low bus reset falls in the middle of a command. The state machine drops to idle from whatever state it is in, the rest of the beats are never issued, a read beat still in its data phase is never forwarded, and the completion pulse is never raised. A status record is cleared only by a separate power-on reset and survives the bus reset. It holds an abort flag and the number of beats that really completed, so higher-level logic can decide how to re-issue the command. An error response from the slave ends the command early with an error flag.

The state machine has five states. S_IDLE waits for a command. S_ADDR drives the first beat's address (NONSEQ) with no data phase pending. S_BURST drives a later beat's address (SEQ) while the previous beat is in its data phase. S_DATA holds only the last beat's data phase. S_ERR is the second cycle of an error response. The transitions are: S_IDLE to S_ADDR on command accept. S_ADDR to S_DATA (one beat) or S_BURST (more beats) when HREADY is high. S_BURST stays in S_BURST while beats remain, or moves to S_DATA after the last address. S_DATA goes to S_IDLE on completion. S_BURST or S_DATA goes to S_ERR on the first error cycle, and S_ERR goes to S_IDLE when HREADY rises. Bus reset forces S_IDLE from every state.

Top module: `burst_bus_master`

## Requirements
- R1: While the synchronised bus reset is active, htrans is IDLE (2'b00), and cmd_ready, done, rd_valid and wr_next are all low. Assertion of hresetn takes effect at once, without waiting for a clock edge.
- R2: A command is accepted on a rising edge where cmd_valid and cmd_ready are both high. cmd_ready is high only in the idle state, and it is high again after done.
- R3: The first beat carries htrans NONSEQ (2'b10) and each later beat carries SEQ (2'b11). The address of each beat is the previous one plus 1 << cmd_size, and hsize equals cmd_size. hburst is SINGLE 3'b000 for one beat, INCR4 3'b011 for 4 beats, INCR8 3'b101 for 8 beats, INCR16 3'b111 for 16 beats, and INCR 3'b001 for any other count. cmd_len holds the beat count minus one.
- R4: While a beat's address phase is stretched by hready low with no error response, haddr, htrans and hwrite hold their values.
- R5: During each write data phase, hwdata equals wr_data. wr_next is high in exactly the cycles in which a write beat completes (hready high, hresp low), so the slave stores one source word per completed beat.
- R6: rd_valid is high with rd_data equal to hrdata in exactly the cycles in which a read beat completes (hready high, hresp low).
- R7: done pulses for one cycle in the cycle in which the final beat completes, with done_err low.
- R8: When hresp is high with hready low during a data phase, the next cycle drives htrans IDLE. done pulses with done_err high in the cycle in which the error response ends. The errored beat is not counted or forwarded, and no later beat is issued.
- R9: A bus reset during a command leaves the beats completed before it in place. No further beat is issued after the reset, the read beat in flight is not forwarded, and done never pulses for that command.
- R10: stat_beats counts the beats completed by the latest command. stat_aborted is set when the bus reset arrives while a command is in flight. Accepting a command clears both. Only por_n resets them, and hresetn leaves them unchanged.
- R11: After hresetn rises, cmd_ready stays low on the first rising edge and goes high on the second rising edge (a two-stage synchroniser).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low bus reset, asynchronous assertion |
| por_n | input | 1 | Active-low power-on reset for the status record |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Sequencer can take a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Start address |
| cmd_len | input | LEN_W | Beat count minus one |
| cmd_size | input | 3 | Transfer size code |
| wr_data | input | DW | Current word from the write source |
| wr_next | output | 1 | Write beat completed; source advances |
| rd_valid | output | 1 | Read beat completed |
| rd_data | output | DW | Read data for the completed beat |
| done | output | 1 | Command finished |
| done_err | output | 1 | Command finished with an error response |
| stat_aborted | output | 1 | Last command was cut by bus reset |
| stat_beats | output | CNT_W | Beats completed by the last command |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Transfer type |
| hwrite | output | 1 | Bus direction |
| hsize | output | 3 | Bus transfer size |
| hburst | output | 3 | Burst type |
| hwdata | output | DW | Bus write data |
| hrdata | input | DW | Bus read data |
| hready | input | 1 | Slave ready |
| hresp | input | 1 | Slave error response |

## Verification
The functions that can meet in one cycle are a beat's completion and the bus reset. The completion edge that is counted and the reset that forbids any further counting can come within a single cycle of each other. The bench provokes this by asserting hresetn just after the third write beat's completion edge, while the fourth beat is already in its data phase. It also asserts reset during the wait cycle of a read beat that has just started its data phase. Each case is judged at the ports: the memory image of the slave model, the number of wr_next and rd_valid pulses, the absence of done, and the status record read after recovery must all agree on exactly the beats that completed before the reset.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ADDR  = 3'd1,
        S_BURST = 3'd2,
        S_DATA  = 3'd3,
        S_ERR   = 3'd4
    } seq_state_t;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam logic [2:0] BU_SINGLE = 3'b000;
    localparam logic [2:0] BU_INCR   = 3'b001;
    localparam logic [2:0] BU_INCR4  = 3'b011;
    localparam logic [2:0] BU_INCR8  = 3'b101;
    localparam logic [2:0] BU_INCR16 = 3'b111;

endpackage

// File: rtl/bbm_rst_sync.sv
module bbm_rst_sync (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n
);
    logic stage1;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stage1 <= 1'b0;
            rst_n  <= 1'b0;
        end else begin
            stage1 <= 1'b1;
            rst_n  <= stage1;
        end
    end
endmodule

// File: rtl/bbm_status.sv
module bbm_status #(
    parameter int MAX_BEATS = 16,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             start,
    input  logic             commit,
    input  logic             finish,
    output logic             aborted,
    output logic [CNT_W-1:0] beats
);
    logic live;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            live    <= 1'b0;
            aborted <= 1'b0;
            beats   <= '0;
        end else if (!rst_n) begin
            if (live) aborted <= 1'b1;
            live <= 1'b0;
        end else if (start) begin
            live    <= 1'b1;
            aborted <= 1'b0;
            beats   <= '0;
        end else begin
            if (commit) beats <= beats + CNT_W'(1);
            if (finish) live <= 1'b0;
        end
    end

    // R10: a bus reset seen with a command in flight marks it aborted
    a_r10_abort_marked: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n && live) |=> aborted);

    // R10: the completed-beat count never exceeds the longest command
    a_r10_beats_bounded: assert property (@(posedge clk) disable iff (!por_n)
        int'(beats) <= MAX_BEATS);
endmodule

// File: rtl/burst_bus_master.sv
module burst_bus_master
    import bbm_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int MAX_BEATS = 16,
    localparam int LEN_W    = $clog2(MAX_BEATS),
    localparam int CNT_W    = $clog2(MAX_BEATS + 1)
) (
    input  logic             hclk,
    input  logic             hresetn,
    input  logic             por_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_write,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [2:0]       cmd_size,
    input  logic [DW-1:0]    wr_data,
    output logic             wr_next,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic             done,
    output logic             done_err,
    output logic             stat_aborted,
    output logic [CNT_W-1:0] stat_beats,
    output logic [AW-1:0]    haddr,
    output logic [1:0]       htrans,
    output logic             hwrite,
    output logic [2:0]       hsize,
    output logic [2:0]       hburst,
    output logic [DW-1:0]    hwdata,
    input  logic [DW-1:0]    hrdata,
    input  logic             hready,
    input  logic             hresp
);
    logic             rst_n;
    seq_state_t       st, st_nx;
    logic [AW-1:0]    addr_q;
    logic [LEN_W-1:0] left_q, len_q;
    logic [2:0]       size_q;
    logic             wr_q;
    logic             accept, data_ph, commit, step;

    bbm_rst_sync u_sync (
        .clk    (hclk),
        .arst_n (hresetn),
        .rst_n  (rst_n)
    );

    assign cmd_ready = rst_n && (st == S_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign data_ph   = (st == S_BURST) || (st == S_DATA);
    assign commit    = data_ph && hready && !hresp;
    assign step      = ((st == S_ADDR && hready) || (st == S_BURST && hready && !hresp))
                       && (left_q != '0);

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (accept) st_nx = S_ADDR;
            S_ADDR:  if (hready) st_nx = (left_q == '0) ? S_DATA : S_BURST;
            S_BURST: begin
                if (hresp && !hready)       st_nx = S_ERR;
                else if (hready && !hresp)  st_nx = (left_q == '0) ? S_DATA : S_BURST;
            end
            S_DATA: begin
                if (hresp && !hready)       st_nx = S_ERR;
                else if (hready && !hresp)  st_nx = S_IDLE;
            end
            S_ERR:   if (hready) st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // state register: bus reset overrides the next-state logic from any state
    always_ff @(posedge hclk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // command and address registers
    always_ff @(posedge hclk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
            len_q  <= '0;
            size_q <= '0;
            wr_q   <= 1'b0;
        end else if (accept) begin
            addr_q <= cmd_addr;
            left_q <= cmd_len;
            len_q  <= cmd_len;
            size_q <= cmd_size;
            wr_q   <= cmd_write;
        end else if (step) begin
            addr_q <= addr_q + (AW'(1) << size_q);
            left_q <= left_q - LEN_W'(1);
        end
    end

    // outputs
    always_comb begin
        htrans   = TR_IDLE;
        done     = 1'b0;
        done_err = 1'b0;
        unique case (st)
            S_IDLE:  ;
            S_ADDR:  htrans = TR_NONSEQ;
            S_BURST: htrans = TR_SEQ;
            S_DATA:  done = hready && !hresp;
            S_ERR: begin
                done     = hready;
                done_err = hready;
            end
            default: ;
        endcase

        if (len_q == '0)         hburst = BU_SINGLE;
        else if (int'(len_q) == 3)  hburst = BU_INCR4;
        else if (int'(len_q) == 7)  hburst = BU_INCR8;
        else if (int'(len_q) == 15) hburst = BU_INCR16;
        else                     hburst = BU_INCR;
    end

    assign haddr    = addr_q;
    assign hwrite   = wr_q;
    assign hsize    = size_q;
    assign hwdata   = (data_ph && wr_q) ? wr_data : '0;
    assign wr_next  = commit && wr_q;
    assign rd_valid = commit && !wr_q;
    assign rd_data  = hrdata;

    bbm_status #(.MAX_BEATS(MAX_BEATS), .CNT_W(CNT_W)) u_stat (
        .clk     (hclk),
        .por_n   (por_n),
        .rst_n   (rst_n),
        .start   (accept),
        .commit  (commit),
        .finish  (done),
        .aborted (stat_aborted),
        .beats   (stat_beats)
    );

    // R1 / R9: nothing leaves the block while bus reset holds
    a_r1_quiet_in_reset: assert property (@(posedge hclk)
        !rst_n |-> (htrans == TR_IDLE && !rd_valid && !wr_next && !done && !cmd_ready));

    // R4: a stretched address phase keeps its address and control
    a_r4_hold_on_wait: assert property (@(posedge hclk) disable iff (!rst_n)
        (htrans[1] && !hready && !hresp) |=> ($stable(haddr) && $stable(htrans) && $stable(hwrite)));

    // R3: a SEQ beat following an accepted beat steps the address by the size
    a_r3_addr_step: assert property (@(posedge hclk) disable iff (!rst_n)
        (htrans == TR_SEQ && $past(htrans[1] && hready)) |-> (haddr == $past(haddr) + (AW'(1) << hsize)));

    // R8: the first error cycle is followed by an idle transfer type
    a_r8_idle_after_error: assert property (@(posedge hclk) disable iff (!rst_n)
        (data_ph && hresp && !hready) |=> (htrans == TR_IDLE));

    // R7: completion only from a data phase or the error tail
    a_r7_done_source: assert property (@(posedge hclk) disable iff (!rst_n)
        done |-> (hready && (st == S_DATA || st == S_ERR)));
endmodule

// File: tb/sim_burst_bus_master.sv
`timescale 1ns/1ps
module sim_burst_bus_master;

    typedef struct packed {
        logic       wr;
        logic [7:0] addr;
        logic [3:0] len;
        logic [2:0] size;
        logic [1:0] waits;
        logic [4:0] err_at;
        logic [4:0] exp_beats;
        logic       exp_err;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h10, 4'd3,  3'd2, 2'd0, 5'd31, 5'd4,  1'b0},
        '{1'b1, 8'h40, 4'd7,  3'd2, 2'd1, 5'd31, 5'd8,  1'b0},
        '{1'b0, 8'h00, 4'd0,  3'd2, 2'd2, 5'd31, 5'd1,  1'b0},
        '{1'b1, 8'h80, 4'd15, 3'd2, 2'd0, 5'd31, 5'd16, 1'b0},
        '{1'b0, 8'h20, 4'd5,  3'd1, 2'd1, 5'd31, 5'd6,  1'b0},
        '{1'b1, 8'hC0, 4'd5,  3'd2, 2'd0, 5'd2,  5'd2,  1'b1},
        '{1'b0, 8'h08, 4'd3,  3'd2, 2'd1, 5'd0,  5'd0,  1'b1}
    };

    logic        clk = 1'b0;
    logic        hresetn = 1'b0;
    logic        por_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_write = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [3:0]  cmd_len = '0;
    logic [2:0]  cmd_size = '0;
    logic [31:0] wr_data;
    logic        wr_next, rd_valid, done, done_err, stat_aborted;
    logic [31:0] rd_data;
    logic [4:0]  stat_beats;
    logic [31:0] haddr, hwdata, hrdata;
    logic [1:0]  htrans;
    logic        hwrite, hready, hresp;
    logic [2:0]  hsize, hburst;

    int nvec = 0;
    int nbad = 0;

    always #2.5 clk = ~clk;

    burst_bus_master u0 (
        .hclk(clk), .hresetn(hresetn), .por_n(por_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_size(cmd_size),
        .wr_data(wr_data), .wr_next(wr_next), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .done_err(done_err), .stat_aborted(stat_aborted), .stat_beats(stat_beats),
        .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hburst(hburst),
        .hwdata(hwdata), .hrdata(hrdata), .hready(hready), .hresp(hresp)
    );

    // write source: advances one word per completed write beat
    logic [7:0] widx = 8'd0;
    always @(posedge clk) if (wr_next) widx <= widx + 8'd1;
    assign wr_data = {24'hC0DE5A, widx};

    // slave model
    logic [31:0] mem [64];
    logic        init_req = 1'b0;
    logic [1:0]  waits = 2'd0;
    logic [4:0]  err_at = 5'd31;
    logic        dp_v, dp_w;
    logic [7:0]  dp_a;
    logic [1:0]  wcnt;
    logic [1:0]  errph;
    int          nbeat = 0;
    int          ncap = 0;
    logic [7:0]  cap_addr [16];
    logic [1:0]  cap_trans [16];
    logic [2:0]  cap_burst, cap_size;

    assign hready = !dp_v || (wcnt == 2'd0 && errph != 2'd1);
    assign hresp  = dp_v && errph != 2'd0;
    assign hrdata = mem[dp_a[7:2]];

    always @(posedge clk or negedge hresetn) begin
        if (!hresetn) begin
            dp_v  <= 1'b0;
            dp_w  <= 1'b0;
            dp_a  <= 8'd0;
            wcnt  <= 2'd0;
            errph <= 2'd0;
        end else begin
            if (init_req)
                for (int i = 0; i < 64; i++) mem[i] <= 32'h1000_0000 + 32'(i);
            if (dp_v && hready) begin
                if (dp_w && !hresp) mem[dp_a[7:2]] <= hwdata;
            end else if (dp_v) begin
                if (wcnt != 2'd0) wcnt <= wcnt - 2'd1;
                if (errph == 2'd1) errph <= 2'd2;
            end
            if (hready) begin
                if (htrans[1]) begin
                    int idx;
                    idx = (htrans == 2'b10) ? 0 : nbeat;
                    nbeat <= idx + 1;
                    ncap  <= idx + 1;
                    dp_v  <= 1'b1;
                    dp_a  <= haddr[7:0];
                    dp_w  <= hwrite;
                    wcnt  <= (idx == int'(err_at)) ? 2'd0 : waits;
                    errph <= (idx == int'(err_at)) ? 2'd1 : 2'd0;
                    if (idx < 16) begin
                        cap_addr[idx]  <= haddr[7:0];
                        cap_trans[idx] <= htrans;
                    end
                    if (htrans == 2'b10) begin
                        cap_burst <= hburst;
                        cap_size  <= hsize;
                    end
                end else begin
                    dp_v  <= 1'b0;
                    errph <= 2'd0;
                end
            end
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [5:0] widx_of(input logic [7:0] a, input logic [2:0] sz, input int k);
        logic [7:0] b;
        b = a + 8'(k << sz);
        return b[7:2];
    endfunction

    function automatic logic [2:0] exp_burst(input logic [3:0] len);
        case (len)
            4'd0:    return 3'b000;
            4'd3:    return 3'b011;
            4'd7:    return 3'b101;
            4'd15:   return 3'b111;
            default: return 3'b001;
        endcase
    endfunction

    task automatic mem_init();
        @(negedge clk); init_req = 1'b1;
        @(negedge clk); init_req = 1'b0;
    endtask

    task automatic issue(input logic wr, input logic [7:0] a, input logic [3:0] len, input logic [2:0] sz);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = {24'd0, a}; cmd_len = len; cmd_size = sz;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input logic [7:0] a, input logic [2:0] sz,
                             output int n, output bit gd, output bit ge);
        logic        held = 1'b0;
        logic [31:0] h_addr = '0;
        logic [1:0]  h_tr = '0;
        n = 0; gd = 1'b0; ge = 1'b0;
        for (int c = 0; c < 300 && !gd; c++) begin
            @(negedge clk);
            if (held) begin
                chk("R4", "address held in wait", haddr, h_addr);
                chk("R4", "htrans held in wait", {30'd0, htrans}, {30'd0, h_tr});
            end
            held   = htrans[1] && !hready && !hresp;
            h_addr = haddr;
            h_tr   = htrans;
            if (rd_valid) begin
                chk("R6", "read beat data", rd_data, 32'h1000_0000 + 32'(widx_of(a, sz, n)));
                n++;
            end
            if (wr_next) n++;
            if (done) begin gd = 1'b1; ge = done_err; end
        end
        @(posedge clk); #1;
    endtask

    initial begin
        #(5.0 * 150000);
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec + 1, nbad + 1);
        $finish;
    end

    initial begin
        int n; bit gd, ge; int cnt; bit sawdone; logic [7:0] base;

        // reset state
        repeat (3) @(negedge clk);
        chk("R1", "htrans in reset", {30'd0, htrans}, 32'd0);
        chk("R1", "cmd_ready in reset", {31'd0, cmd_ready}, 32'd0);
        chk("R1", "done in reset", {31'd0, done}, 32'd0);
        chk("R10", "status after power-on", {26'd0, stat_aborted, stat_beats}, 32'd0);
        por_n = 1'b1;
        @(negedge clk); hresetn = 1'b1;
        @(posedge clk); #1;
        chk("R11", "ready after first edge", {31'd0, cmd_ready}, 32'd0);
        @(posedge clk); #1;
        chk("R11", "ready after second edge", {31'd0, cmd_ready}, 32'd1);

        // table-driven commands
        for (int vi = 0; vi < NV; vi++) begin
            vec_t v;
            v = VEC[vi];
            waits = v.waits; err_at = v.err_at;
            mem_init();
            base = widx;
            issue(v.wr, v.addr, v.len, v.size);
            wait_done(v.addr, v.size, n, gd, ge);
            chk("R7", "done raised", {31'd0, gd}, 32'd1);
            chk(v.exp_err ? "R8" : "R7", "done_err", {31'd0, ge}, {31'd0, v.exp_err});
            chk("R10", "status beats", {27'd0, stat_beats}, {27'd0, v.exp_beats});
            chk("R10", "status aborted", {31'd0, stat_aborted}, 32'd0);
            chk(v.wr ? "R5" : "R6", "beats handed over", 32'(n), {27'd0, v.exp_beats});
            chk("R2", "ready after done", {31'd0, cmd_ready}, 32'd1);
            if (v.wr) begin
                for (int k = 0; k < int'(v.exp_beats); k++)
                    chk("R5", "written word", mem[widx_of(v.addr, v.size, k)], {24'hC0DE5A, base + 8'(k)});
            end
            if (v.exp_err) begin
                chk("R8", "beats issued before stop", 32'(ncap), 32'(int'(v.exp_beats) + 1));
                chk("R8", "errored word untouched", mem[widx_of(v.addr, v.size, int'(v.exp_beats))],
                    32'h1000_0000 + 32'(widx_of(v.addr, v.size, int'(v.exp_beats))));
                chk("R8", "htrans idle after error", {30'd0, htrans}, 32'd0);
            end else begin
                chk("R3", "beats on bus", 32'(ncap), 32'(int'(v.len) + 1));
                chk("R3", "hburst", {29'd0, cap_burst}, {29'd0, exp_burst(v.len)});
                chk("R3", "hsize", {29'd0, cap_size}, {29'd0, v.size});
                for (int k = 0; k <= int'(v.len); k++) begin
                    chk("R3", "beat address", {24'd0, cap_addr[k]}, {24'd0, v.addr + 8'(k << v.size)});
                    chk("R3", "beat type", {30'd0, cap_trans[k]}, (k == 0) ? 32'd2 : 32'd3);
                end
            end
        end

        // bus reset right after the third write beat completes
        waits = 2'd0; err_at = 5'd31;
        mem_init();
        base = widx;
        issue(1'b1, 8'h40, 4'd7, 3'd2);
        cnt = 0; sawdone = 1'b0;
        while (cnt < 3) begin
            @(negedge clk);
            if (wr_next) cnt++;
            if (done) sawdone = 1'b1;
        end
        @(posedge clk); #1;
        hresetn = 1'b0; #1;
        chk("R9", "htrans idle at reset", {30'd0, htrans}, 32'd0);
        chk("R1", "wr_next low at reset", {31'd0, wr_next}, 32'd0);
        chk("R1", "cmd_ready low at reset", {31'd0, cmd_ready}, 32'd0);
        repeat (3) @(negedge clk);
        hresetn = 1'b1;
        @(posedge clk); #1;
        chk("R11", "ready held after release", {31'd0, cmd_ready}, 32'd0);
        @(posedge clk); #1;
        chk("R11", "ready back after release", {31'd0, cmd_ready}, 32'd1);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (done) sawdone = 1'b1;
            chk("R9", "no beat after reset", {30'd0, htrans}, 32'd0);
        end
        chk("R9", "no done for cut write", {31'd0, sawdone}, 32'd0);
        chk("R10", "aborted after cut write", {31'd0, stat_aborted}, 32'd1);
        chk("R10", "beats kept across reset", {27'd0, stat_beats}, 32'd3);
        for (int k = 0; k < 8; k++)
            chk("R9", "memory after cut write", mem[6'd16 + 6'(k)],
                (k < 3) ? {24'hC0DE5A, base + 8'(k)} : 32'h1000_0000 + 32'(16 + k));

        // bus reset during the wait cycle of the second read beat
        waits = 2'd1;
        issue(1'b0, 8'h10, 4'd3, 3'd2);
        cnt = 0;
        while (cnt < 1) begin
            @(negedge clk);
            if (rd_valid) cnt++;
        end
        @(posedge clk); #1;
        hresetn = 1'b0; #1;
        chk("R9", "read not forwarded at reset", {31'd0, rd_valid}, 32'd0);
        sawdone = 1'b0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            if (rd_valid) cnt++;
            if (done) sawdone = 1'b1;
        end
        hresetn = 1'b1;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            if (rd_valid) cnt++;
            if (done) sawdone = 1'b1;
        end
        chk("R9", "read beats forwarded", 32'(cnt), 32'd1);
        chk("R9", "no done for cut read", {31'd0, sawdone}, 32'd0);
        chk("R10", "aborted after cut read", {31'd0, stat_aborted}, 32'd1);
        chk("R10", "beats of cut read", {27'd0, stat_beats}, 32'd1);

        // re-issue of the cut write completes and clears the abort mark
        waits = 2'd0;
        base = widx;
        issue(1'b1, 8'h40, 4'd7, 3'd2);
        wait_done(8'h40, 3'd2, n, gd, ge);
        chk("R7", "re-issued write done", {31'd0, gd}, 32'd1);
        chk("R10", "abort cleared by new command", {31'd0, stat_aborted}, 32'd0);
        chk("R10", "beats of re-issue", {27'd0, stat_beats}, 32'd8);
        for (int k = 0; k < 8; k++)
            chk("R5", "re-issued word", mem[6'd16 + 6'(k)], {24'hC0DE5A, base + 8'(k)});

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule